// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent down-counters behind a small register port with one access per cycle. Each channel has a one-byte control register and a full-word count register. Software loads a start value, picks a mode and sets the enable bit. The channel then decrements once per clock. In free-run mode the counter wraps past zero, so a channel loaded with all ones serves as an elapsed-time source read through its count register. In one-shot mode the channel fires once and disarms itself. In periodic mode it fires and reloads the last value software wrote, for as long as it stays enabled.

Every channel owns one interrupt line, a single-cycle high pulse on the bit that matches its index. The register port is a plain strobe interface with no back-pressure. A write takes effect at the next rising edge, and read data is valid combinationally in the same cycle as `bus_rd`. No stream handshake applies, because no data is queued anywhere in the block.

Top module: `timer_bank`

## Requirements
- R1: After reset every control register and count register reads zero, all interrupt lines are low, and `bus_rdata` is zero.
- R2: Channel t decodes its control register at byte address t*8 and its count register at t*8+4. A control write needs byte lane 0 (`bus_wstrb[0]`) and stores `bus_wdata[7:0]`. A control read returns the stored byte zero-extended.
- R3: A count write is accepted only when all four byte strobes are set. It loads the counter and the reload value. A partial write leaves the count unchanged.
- R4: While control bit 0 (enable) is set, the count drops by one per clock. While enable is clear the count holds. Writing zero to the control register stops the channel, and the count at that edge still takes its final decrement.
- R5: Control bits [5:4] select the mode. With value 0 (free-run) or 3 (treated the same), an enabled channel wraps from 0 to 0xFFFFFFFF and never raises its interrupt.
- R6: With mode value 1 (one-shot), a channel loaded with N and enabled pulses its interrupt for one cycle, N+1 clocks after the enabling edge. On that same edge it clears its enable bit, leaving the control readback with bit 0 low and the count at 0.
- R7: With mode value 2 (periodic), when the count is 0 the channel pulses its interrupt and loads the last written count value on the same edge. The interrupt therefore recurs every reload+1 clocks.
- R8: Interrupt bit t belongs to channel t only, and channels running at the same time produce independent pulses on their own bits.
- R9: Addresses whose two low bits are not zero, or which lie at or beyond byte 64, read as zero, and writes to them change no register.
- R10: A count write on the same edge as a decrement or a reload wins: the count after that edge equals the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned the same cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, zero when not reading a mapped register |
| irq | output | 8 | Per-channel single-cycle expiry pulses |

## Verification
The assertions assume that at most one register access happens per cycle. They also assume reset is driven low from time zero, so channel state is known before any property is checked. The expiry properties apply only when no control or count write lands on the same edge, and they use the strobes to exclude those edges. The stimulus changes bus inputs one time unit after a rising edge and samples results at the falling edge. It never asserts read and write together, and it shuts down the free-running and periodic channels before later sections, so the predicted interrupt vector only ever involves the channels under test.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_RSVD   = 2'd3
  } tmr_mode_e;

  localparam int CTRL_W     = 8;
  localparam int EN_BIT     = 0;
  localparam int MODE_LSB   = 4;
  localparam int CH_STRIDE  = 8;
  localparam int CNT_OFFSET = 4;
endpackage

// File: rtl/timer_regdec.sv
module timer_regdec #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BUS_W/8-1:0]        wstrb,
  output logic [NUM_CH-1:0]         ctrl_we,
  output logic [NUM_CH-1:0]         cnt_we,
  output logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0] sel_ch,
  output logic                      sel_cnt,
  output logic                      hit
);
  import timer_pkg::*;

  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int BANK_SIZE = NUM_CH * CH_STRIDE;
  localparam logic [ADDR_W:0] BANK_END = (ADDR_W+1)'(BANK_SIZE);

  logic in_bank, aligned;

  always_comb begin
    in_bank = ({1'b0, addr} < BANK_END);
    aligned = (addr[1:0] == 2'b00);
    hit     = in_bank && aligned;
    sel_ch  = addr[CH_W+2:3];
    sel_cnt = addr[2];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_strobe
    logic mine;
    assign mine       = wr_en && hit && (sel_ch == CH_W'(i));
    assign ctrl_we[i] = mine && !sel_cnt && wstrb[0];
    assign cnt_we[i]  = mine && sel_cnt && (&wstrb);
  end

  // R9: a single bus write reaches at most one register of the bank
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, cnt_we}));
endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W = 32,
  parameter int BUS_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_we,
  input  logic                      cnt_we,
  input  logic [BUS_W-1:0]          wdata,
  output logic [timer_pkg::CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      irq
);
  import timer_pkg::*;

  logic [CTRL_W-1:0] ctrl_r;
  logic [CNT_W-1:0]  cnt_r, reload_r;
  logic              irq_r;
  logic              armed, at_zero;
  tmr_mode_e         mode;

  always_comb begin
    armed   = ctrl_r[EN_BIT];
    mode    = tmr_mode_e'(ctrl_r[MODE_LSB+1:MODE_LSB]);
    at_zero = (cnt_r == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r   <= '0;
      cnt_r    <= '0;
      reload_r <= '0;
      irq_r    <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      if (armed) begin
        if (at_zero && mode == MODE_ONCE) begin
          irq_r          <= 1'b1;
          ctrl_r[EN_BIT] <= 1'b0;
        end else if (at_zero && mode == MODE_RELOAD) begin
          irq_r <= 1'b1;
          cnt_r <= reload_r;
        end else begin
          cnt_r <= cnt_r - 1'b1;
        end
      end
      if (ctrl_we) ctrl_r <= wdata[CTRL_W-1:0];
      if (cnt_we) begin
        cnt_r    <= wdata[CNT_W-1:0];
        reload_r <= wdata[CNT_W-1:0];
      end
    end
  end

  assign ctrl_q = ctrl_r;
  assign cnt_q  = cnt_r;
  assign irq    = irq_r;

  // R4: a disabled channel keeps its count unless software writes it
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cnt_we) |=> $stable(cnt_r));

  // R5: free-run and reserved modes never interrupt
  a_r5_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode == MODE_FREE || mode == MODE_RSVD)) |=> !irq_r);

  // R6: one-shot expiry pulses, disarms and parks at zero
  a_r6_once_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && at_zero && mode == MODE_ONCE && !ctrl_we && !cnt_we)
    |=> (irq_r && !ctrl_r[EN_BIT] && cnt_r == '0));

  // R7: periodic expiry pulses and restores the reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && at_zero && mode == MODE_RELOAD && !ctrl_we && !cnt_we)
    |=> (irq_r && cnt_r == $past(reload_r)));

  // R10: a count write overrides counting on the same edge
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_r == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/timer_rdmux.sv
module timer_rdmux #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int BUS_W  = 32
) (
  input  logic                                  rd_en,
  input  logic                                  hit,
  input  logic [((NUM_CH>1)?$clog2(NUM_CH):1)-1:0] sel_ch,
  input  logic                                  sel_cnt,
  input  logic [NUM_CH-1:0][timer_pkg::CTRL_W-1:0] ctrl_all,
  input  logic [NUM_CH-1:0][CNT_W-1:0]          cnt_all,
  output logic [BUS_W-1:0]                      rdata
);
  import timer_pkg::*;

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      if (sel_cnt) rdata = BUS_W'(cnt_all[sel_ch]);
      else         rdata = BUS_W'(ctrl_all[sel_ch]);
    end
  end
endmodule

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic [BUS_W/8-1:0]   bus_wstrb,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NUM_CH-1:0]    irq
);
  import timer_pkg::*;

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]             ctrl_we, cnt_we;
  logic [CH_W-1:0]               sel_ch;
  logic                          sel_cnt, hit;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;

  timer_regdec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wstrb   (bus_wstrb),
    .ctrl_we (ctrl_we),
    .cnt_we  (cnt_we),
    .sel_ch  (sel_ch),
    .sel_cnt (sel_cnt),
    .hit     (hit)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    timer_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (ctrl_we[i]),
      .cnt_we  (cnt_we[i]),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_all[i]),
      .cnt_q   (cnt_all[i]),
      .irq     (irq[i])
    );
  end

  timer_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_rd (
    .rd_en    (bus_rd),
    .hit      (hit),
    .sel_ch   (sel_ch),
    .sel_cnt  (sel_cnt),
    .ctrl_all (ctrl_all),
    .cnt_all  (cnt_all),
    .rdata    (bus_rdata)
  );

  // R9: reads outside the decoded map return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |-> (bus_rdata == '0));
endmodule

// File: tb/timer_bank_test.sv
module timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq;

  always #5 clk = ~clk;

  timer_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    int          cyc;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t rd_q[$];
  item_t irq_q[$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: compare scheduled expectations in their cycle
  always @(negedge clk) begin
    item_t it;
    while (rd_q.size() > 0 && rd_q[0].cyc <= cyc) begin
      it = rd_q.pop_front();
      check(it.req, bus_rdata, it.val);
    end
    while (irq_q.size() > 0 && irq_q[0].cyc <= cyc) begin
      it = irq_q.pop_front();
      check(it.req, {24'b0, irq}, it.val);
    end
  end

  function automatic logic [7:0] ctrl_a(input int t);
    return 8'(t * 8);
  endfunction
  function automatic logic [7:0] cnt_a(input int t);
    return 8'(t * 8 + 4);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1;
    rd_q.push_back('{cyc, exp, req});
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic expect_irq(input int at, input logic [7:0] v, input string req);
    irq_q.push_back('{at, {24'b0, v}, req});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int a, b, w;
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(ctrl_a(0), 32'h0, "R1");
    rd(cnt_a(7), 32'h0, "R1");
    expect_irq(cyc, 8'h00, "R1");
    check("R1", bus_rdata, 32'h0);
    idle(1);

    // R2: control decode, byte lane 0, zero-extended readback
    wr(ctrl_a(5), 32'h20, 4'h1);
    rd(ctrl_a(5), 32'h20, "R2");
    wr(ctrl_a(5), 32'h31, 4'h2);
    rd(ctrl_a(5), 32'h20, "R2");
    wr(ctrl_a(5), 32'hABCDEF24, 4'hF);
    rd(ctrl_a(5), 32'h24, "R2");

    // R3: full-word count writes only
    wr(cnt_a(2), 32'h1234, 4'hF);
    rd(cnt_a(2), 32'h1234, "R3");
    wr(cnt_a(2), 32'hFFFF, 4'h3);
    rd(cnt_a(2), 32'h1234, "R3");

    // R4: counting while enabled
    wr(ctrl_a(2), 32'h01, 4'h1);
    a = cyc;
    idle(2);
    rd(cnt_a(2), 32'h1234 - 32'(cyc - a), "R4");

    // R10: count write beats the decrement on the same edge
    wr(cnt_a(2), 32'd100, 4'hF);
    w = cyc;
    rd(cnt_a(2), 32'd100, "R10");
    idle(3);
    rd(cnt_a(2), 32'd100 - 32'(cyc - w), "R10");

    // R4: writing zero stops the channel
    wr(ctrl_a(2), 32'h0, 4'h1);
    b = cyc;
    idle(4);
    rd(cnt_a(2), 32'd100 - 32'(b - w), "R4");

    // R5: free-run wraps, no interrupt
    wr(cnt_a(6), 32'd2, 4'hF);
    wr(ctrl_a(6), 32'h01, 4'h1);
    a = cyc;
    for (int k = 1; k <= 4; k++) expect_irq(a + k, 8'h00, "R5");
    idle(3);
    rd(cnt_a(6), 32'hFFFFFFFF - 32'(cyc - a - 3), "R5");
    wr(cnt_a(7), 32'd1, 4'hF);
    wr(ctrl_a(7), 32'h31, 4'h1);
    a = cyc;
    idle(2);
    rd(cnt_a(7), 32'hFFFFFFFF - 32'(cyc - a - 2), "R5");
    wr(ctrl_a(6), 32'h0, 4'h1);
    wr(ctrl_a(7), 32'h0, 4'h1);

    // R6: one-shot on channel 1, N = 5
    wr(cnt_a(1), 32'd5, 4'hF);
    wr(ctrl_a(1), 32'h11, 4'h1);
    a = cyc;
    for (int k = 1; k <= 8; k++) expect_irq(a + k, (k == 6) ? 8'h02 : 8'h00, "R6");
    idle(10);
    rd(ctrl_a(1), 32'h10, "R6");
    rd(cnt_a(1), 32'h0, "R6");

    // R7 and R8: periodic channel 4 (reload 3) with one-shot channel 0 (N = 6)
    wr(cnt_a(4), 32'd3, 4'hF);
    wr(cnt_a(0), 32'd6, 4'hF);
    wr(ctrl_a(4), 32'h21, 4'h1);
    a = cyc;
    wr(ctrl_a(0), 32'h11, 4'h1);
    b = cyc;
    for (int k = 1; k <= 16; k++) begin
      v = 8'h00;
      if ((b + k - a) >= 4 && ((b + k - a) % 4) == 0) v = v | 8'h10;
      if (k == 7) v = v | 8'h01;
      expect_irq(b + k, v, "R7,R8");
    end
    idle(5);
    rd(cnt_a(4), 32'd3 - 32'((cyc - a) % 4), "R7");
    idle(12);
    wr(ctrl_a(4), 32'h0, 4'h1);

    // R9: unmapped offsets
    wr(8'h0D, 32'hABCD, 4'hF);
    wr(8'h48, 32'h21, 4'h1);
    rd(8'h0D, 32'h0, "R9");
    rd(8'h48, 32'h0, "R9");
    rd(cnt_a(1), 32'h0, "R9");
    rd(ctrl_a(1), 32'h10, "R9");
    expect_irq(cyc + 1, 8'h00, "R9");

    idle(3);
    finish_run();
  end
endmodule